// File: doc/BRIEF.md
# Concatenated Vertical Toggle Pattern Generator

This block produces one vertical clock level for an image-sensor line. Four pattern groups are stored side by side. Each group holds four toggle positions and its own timing fields: start position, resting polarity, period length and repeat count. A pixel-count timebase drives a pattern counter. Each time that counter reaches a live toggle position, the output inverts.

With the merge mode on, the toggle lists of all four groups act as one list of up to sixteen positions. Only the first group's timing fields shape the waveform. This makes a longer pattern than a single group allows. A designer who needs only eight toggles programs the second, third and fourth groups identically. One who needs twelve programs the third and fourth identically. Repeated positions cost no extra edges. With the merge mode off, a group-select input picks one group, and that group's toggles and timing fields act alone.

A line-start strobe arms the sequence. The output then waits at its polarity level until the start position and plays the pattern period by period for the programmed number of repeats. After that it rests at the polarity level again.

Top module: `vtog_concat_gen`

## Requirements
- R1: While reset is asserted, `vclk_o` is 0.
- R2: While `enable_i` is low, `line_start_i` and `pix_tick_i` have no effect. One clock after any cycle with `enable_i` low, `vclk_o` equals the effective polarity. The effective group is group 0 when `concat_en_i` is 1 and group `grp_sel_i` otherwise.
- R3: Ticks are numbered k = 0, 1, 2, … from the first tick after a line start. For every tick with k below the effective start position, and for every tick after the last repeat period ends, the output set at that tick's clock edge is the effective polarity.
- R4: With `concat_en_i` = 0, only the selected group's four toggles apply, together with that group's own start, length, repeat count and polarity. Group g occupies bits [g*4*POS_W +: 4*POS_W] of `tog_pos_i`, and toggle t sits POS_W bits higher than toggle t-1.
- R5: With `concat_en_i` = 1, the toggle positions of all groups apply together. A position equal to all ones (0x1FFF) is unused and never matches.
- R6: With `concat_en_i` = 1, the start, length, repeat count and polarity fields of groups 1 to 3 have no effect on the output, even when they change while a line is running.
- R7: At tick k ≥ start, let q = k − start and w = q mod length. While q < length × repeats, the output is the polarity inverted once for each distinct live toggle position in 0..w. Each period therefore begins again from the polarity level.
- R8: Several slots holding the same position invert the output once at that count, not once per slot.
- R9: In a cycle without `pix_tick_i` and without a line start, the pattern does not advance and `vclk_o` holds its value.
- R10: A line start restarts the sequence even in the middle of a pattern, and `vclk_o` equals the polarity on the next clock. A tick in the same cycle as a line start is not counted.
- R11: If the effective length or repeat count is 0, a line produces no toggles and `vclk_o` stays at the polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Generator enable |
| concat_en_i | input | 1 | Merge the toggle lists of all groups under group 0 timing |
| grp_sel_i | input | GSEL_W | Group used alone when merging is off |
| line_start_i | input | 1 | One-cycle line-start strobe |
| pix_tick_i | input | 1 | Pixel-count timebase advance |
| tog_pos_i | input | NGRP*NTOG*POS_W | Toggle positions, group-major |
| start_i | input | NGRP*POS_W | Start position per group |
| len_i | input | NGRP*POS_W | Period length per group |
| rep_i | input | NGRP*REP_W | Repeat count per group |
| pol_i | input | NGRP | Resting polarity per group |
| vclk_o | output | 1 | Vertical clock level |

## Verification
The hardest case is showing that the timing fields of groups 1 to 3 are ignored while their toggles still count. The stimulus rewrites those fields with random values on every clock of a running merged line. The model, which reads only group 0 timing, must still agree with the output on every cycle.

Two other cases are hard to reach from the ports. Duplicate toggles are reached by programming the last three groups identically and sharing one position with group 0. The pattern-counter behaviour across period boundaries is reached with sparse random ticks and with line starts placed mid-pattern and on a tick cycle.

// File: rtl/vtog_pkg.sv
package vtog_pkg;

    localparam int unsigned VTOG_NGRP  = 4;
    localparam int unsigned VTOG_NTOG  = 4;
    localparam int unsigned VTOG_POS_W = 13;
    localparam int unsigned VTOG_REP_W = 5;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_RUN  = 2'd2,
        PH_DONE = 2'd3
    } vtog_phase_e;

endpackage

// File: rtl/vtog_cfg_sel.sv
module vtog_cfg_sel #(
    parameter int unsigned NGRP   = 4,
    parameter int unsigned POS_W  = 13,
    parameter int unsigned REP_W  = 5,
    parameter int unsigned GSEL_W = 2
) (
    input  logic                    concat_i,
    input  logic [GSEL_W-1:0]       sel_i,
    input  logic [NGRP*POS_W-1:0]   start_i,
    input  logic [NGRP*POS_W-1:0]   len_i,
    input  logic [NGRP*REP_W-1:0]   rep_i,
    input  logic [NGRP-1:0]         pol_i,
    output logic [POS_W-1:0]        start_o,
    output logic [POS_W-1:0]        len_o,
    output logic [REP_W-1:0]        rep_o,
    output logic                    pol_o,
    output logic [NGRP-1:0]         grp_en_o
);

    logic [POS_W-1:0] start_arr [NGRP];
    logic [POS_W-1:0] len_arr   [NGRP];
    logic [REP_W-1:0] rep_arr   [NGRP];
    logic [GSEL_W-1:0] idx;

    for (genvar g = 0; g < NGRP; g++) begin : g_unpack
        assign start_arr[g] = start_i[g*POS_W +: POS_W];
        assign len_arr[g]   = len_i[g*POS_W +: POS_W];
        assign rep_arr[g]   = rep_i[g*REP_W +: REP_W];
        // toggles of a group are live when merging, or when it is the chosen one
        assign grp_en_o[g]  = concat_i | (sel_i == GSEL_W'(g));
    end

    always_comb begin
        idx = concat_i ? '0 : sel_i;
        if (int'(idx) >= int'(NGRP)) begin
            idx = '0;
        end
        start_o = start_arr[idx];
        len_o   = len_arr[idx];
        rep_o   = rep_arr[idx];
        pol_o   = pol_i[idx];
    end

endmodule

// File: rtl/vtog_match.sv
module vtog_match #(
    parameter int unsigned NGRP  = 4,
    parameter int unsigned NTOG  = 4,
    parameter int unsigned POS_W = 13
) (
    input  logic [POS_W-1:0]           pos_i,
    input  logic [NGRP*NTOG*POS_W-1:0] tog_i,
    input  logic [NGRP-1:0]            grp_en_i,
    output logic                       hit_o
);

    localparam int unsigned      NSLOT    = NGRP * NTOG;
    localparam logic [POS_W-1:0] POS_NONE = '1;

    logic [NSLOT-1:0] slot_hit;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        for (genvar t = 0; t < NTOG; t++) begin : g_tog
            localparam int unsigned SLOT = g * NTOG + t;
            logic [POS_W-1:0] slot_pos;
            assign slot_pos       = tog_i[SLOT*POS_W +: POS_W];
            assign slot_hit[SLOT] = grp_en_i[g] && (slot_pos != POS_NONE)
                                    && (slot_pos == pos_i);
        end
    end

    // any number of equal slots collapse into one inversion
    assign hit_o = |slot_hit;

endmodule

// File: rtl/vtog_seq.sv
module vtog_seq
    import vtog_pkg::*;
#(
    parameter int unsigned POS_W = 13,
    parameter int unsigned REP_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              line_start_i,
    input  logic              pix_tick_i,
    input  logic [POS_W-1:0]  start_i,
    input  logic [POS_W-1:0]  len_i,
    input  logic [REP_W-1:0]  rep_i,
    input  logic              pol_i,
    input  logic              hit_i,
    output logic [POS_W-1:0]  eval_pos_o,
    output logic              level_o,
    output vtog_phase_e       phase_o
);

    typedef struct packed {
        vtog_phase_e       phase;
        logic [POS_W-1:0]  hcnt;
        logic [POS_W-1:0]  vcnt;
        logic [REP_W-1:0]  reps;
        logic              lvl;
    } seq_t;

    localparam seq_t SEQ_RST = '{phase: PH_IDLE, hcnt: '0, vcnt: '0, reps: '0, lvl: 1'b0};

    seq_t st_d, st_q;
    logic at_start, step, last_slot, last_rep, base_lvl;

    always_comb begin
        st_d       = st_q;
        at_start   = (st_q.phase == PH_PRE) && (st_q.hcnt == start_i);
        eval_pos_o = (st_q.phase == PH_RUN) ? st_q.vcnt : '0;
        last_slot  = (eval_pos_o == (len_i - POS_W'(1)));
        last_rep   = (st_q.reps == (rep_i - REP_W'(1)));
        base_lvl   = (eval_pos_o == '0) ? pol_i : st_q.lvl;
        step       = 1'b0;

        if (!enable_i) begin
            st_d.phase = PH_IDLE;
            st_d.hcnt  = '0;
            st_d.vcnt  = '0;
            st_d.reps  = '0;
            st_d.lvl   = pol_i;
        end else if (line_start_i) begin
            st_d.phase = ((len_i == '0) || (rep_i == '0)) ? PH_DONE : PH_PRE;
            st_d.hcnt  = '0;
            st_d.vcnt  = '0;
            st_d.reps  = '0;
            st_d.lvl   = pol_i;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: st_d.lvl = pol_i;
                PH_PRE: begin
                    if (pix_tick_i) begin
                        if (at_start) begin
                            step = 1'b1;
                        end else begin
                            st_d.hcnt = st_q.hcnt + POS_W'(1);
                        end
                    end
                end
                PH_RUN:  step = pix_tick_i;
                PH_DONE: begin
                    if (pix_tick_i) begin
                        st_d.lvl = pol_i;
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase

            if (step) begin
                st_d.lvl = base_lvl ^ hit_i;
                if (last_slot) begin
                    st_d.vcnt = '0;
                    if (last_rep) begin
                        st_d.phase = PH_DONE;
                    end else begin
                        st_d.reps  = st_q.reps + REP_W'(1);
                        st_d.phase = PH_RUN;
                    end
                end else begin
                    st_d.vcnt  = eval_pos_o + POS_W'(1);
                    st_d.phase = PH_RUN;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= SEQ_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.lvl;
    assign phase_o = st_q.phase;

endmodule

// File: rtl/vtog_concat_gen.sv
module vtog_concat_gen
    import vtog_pkg::*;
#(
    parameter int unsigned NGRP   = VTOG_NGRP,
    parameter int unsigned NTOG   = VTOG_NTOG,
    parameter int unsigned POS_W  = VTOG_POS_W,
    parameter int unsigned REP_W  = VTOG_REP_W,
    parameter int unsigned GSEL_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       enable_i,
    input  logic                       concat_en_i,
    input  logic [GSEL_W-1:0]          grp_sel_i,
    input  logic                       line_start_i,
    input  logic                       pix_tick_i,
    input  logic [NGRP*NTOG*POS_W-1:0] tog_pos_i,
    input  logic [NGRP*POS_W-1:0]      start_i,
    input  logic [NGRP*POS_W-1:0]      len_i,
    input  logic [NGRP*REP_W-1:0]      rep_i,
    input  logic [NGRP-1:0]            pol_i,
    output logic                       vclk_o
);

    logic [POS_W-1:0] eff_start, eff_len, eval_pos;
    logic [REP_W-1:0] eff_rep;
    logic             eff_pol, hit;
    logic [NGRP-1:0]  grp_en;
    vtog_phase_e      seq_phase;

    vtog_cfg_sel #(
        .NGRP(NGRP), .POS_W(POS_W), .REP_W(REP_W), .GSEL_W(GSEL_W)
    ) u_cfg (
        .concat_i (concat_en_i),
        .sel_i    (grp_sel_i),
        .start_i  (start_i),
        .len_i    (len_i),
        .rep_i    (rep_i),
        .pol_i    (pol_i),
        .start_o  (eff_start),
        .len_o    (eff_len),
        .rep_o    (eff_rep),
        .pol_o    (eff_pol),
        .grp_en_o (grp_en)
    );

    vtog_match #(
        .NGRP(NGRP), .NTOG(NTOG), .POS_W(POS_W)
    ) u_match (
        .pos_i    (eval_pos),
        .tog_i    (tog_pos_i),
        .grp_en_i (grp_en),
        .hit_o    (hit)
    );

    vtog_seq #(
        .POS_W(POS_W), .REP_W(REP_W)
    ) u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .enable_i     (enable_i),
        .line_start_i (line_start_i),
        .pix_tick_i   (pix_tick_i),
        .start_i      (eff_start),
        .len_i        (eff_len),
        .rep_i        (eff_rep),
        .pol_i        (eff_pol),
        .hit_i        (hit),
        .eval_pos_o   (eval_pos),
        .level_o      (vclk_o),
        .phase_o      (seq_phase)
    );

endmodule

// File: rtl/vtog_concat_chk.sv
module vtog_concat_chk
    import vtog_pkg::*;
#(
    parameter int unsigned NGRP   = 4,
    parameter int unsigned POS_W  = 13,
    parameter int unsigned REP_W  = 5,
    parameter int unsigned GSEL_W = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  enable_i,
    input  logic                  concat_en_i,
    input  logic [GSEL_W-1:0]     grp_sel_i,
    input  logic                  line_start_i,
    input  logic                  pix_tick_i,
    input  logic [NGRP*POS_W-1:0] len_i,
    input  logic [NGRP*REP_W-1:0] rep_i,
    input  logic [NGRP-1:0]       pol_i,
    input  logic                  vclk_o,
    input  vtog_phase_e           phase_i
);

    int unsigned       g_eff;
    logic              pol_eff;
    logic [POS_W-1:0]  len_eff;
    logic [REP_W-1:0]  rep_eff;

    always_comb begin
        g_eff = concat_en_i ? 0 : int'(grp_sel_i);
        if (g_eff >= NGRP) begin
            g_eff = 0;
        end
        pol_eff = pol_i[g_eff];
        len_eff = len_i[g_eff*POS_W +: POS_W];
        rep_eff = rep_i[g_eff*REP_W +: REP_W];
    end

    a_r2_disabled_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (vclk_o == $past(pol_eff)));

    a_r10_restart_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && line_start_i) |=> (vclk_o == $past(pol_eff)));

    a_r9_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !line_start_i && !pix_tick_i && (phase_i != PH_IDLE))
        |=> $stable(vclk_o));

    a_r3_done_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !line_start_i && pix_tick_i && (phase_i == PH_DONE))
        |=> (vclk_o == $past(pol_eff)));

    a_r11_zero_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && line_start_i && ((len_eff == '0) || (rep_eff == '0)))
        |=> (phase_i == PH_DONE));

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            a_r1_reset_low: assert (vclk_o == 1'b0);
        end
    end

endmodule

bind vtog_concat_gen vtog_concat_chk #(
    .NGRP(NGRP), .POS_W(POS_W), .REP_W(REP_W), .GSEL_W(GSEL_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .concat_en_i  (concat_en_i),
    .grp_sel_i    (grp_sel_i),
    .line_start_i (line_start_i),
    .pix_tick_i   (pix_tick_i),
    .len_i        (len_i),
    .rep_i        (rep_i),
    .pol_i        (pol_i),
    .vclk_o       (vclk_o),
    .phase_i      (seq_phase)
);

// File: tb/vtog_concat_gen_tb.sv
`timescale 1ns/1ps
module vtog_concat_gen_tb_top;

    localparam int NG = 4;
    localparam int NT = 4;
    localparam int PW = 13;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic concat_en = 1'b1;
    logic [1:0] grp_sel = 2'd0;
    logic line_start = 1'b0;
    logic pix_tick = 1'b0;
    logic vclk;

    logic [PW-1:0] tog [NG][NT];
    logic [PW-1:0] st_a [NG];
    logic [PW-1:0] ln_a [NG];
    logic [RW-1:0] rp_a [NG];
    logic          pl_a [NG];

    logic [NG*NT*PW-1:0] tog_flat;
    logic [NG*PW-1:0]    start_flat, len_flat;
    logic [NG*RW-1:0]    rep_flat;
    logic [NG-1:0]       pol_flat;

    always_comb begin
        for (int g = 0; g < NG; g++) begin
            start_flat[g*PW +: PW] = st_a[g];
            len_flat[g*PW +: PW]   = ln_a[g];
            rep_flat[g*RW +: RW]   = rp_a[g];
            pol_flat[g]            = pl_a[g];
            for (int t = 0; t < NT; t++) begin
                tog_flat[(g*NT+t)*PW +: PW] = tog[g][t];
            end
        end
    end

    vtog_concat_gen dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .enable_i     (enable),
        .concat_en_i  (concat_en),
        .grp_sel_i    (grp_sel),
        .line_start_i (line_start),
        .pix_tick_i   (pix_tick),
        .tog_pos_i    (tog_flat),
        .start_i      (start_flat),
        .len_i        (len_flat),
        .rep_i        (rep_flat),
        .pol_i        (pol_flat),
        .vclk_o       (vclk)
    );

    always #2.5 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    checking = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference ----------------
    int   togq[$];
    int   pos;
    bit   active = 0;
    logic exp_out = 1'b0;

    function automatic int eff_grp();
        return concat_en ? 0 : int'(grp_sel);
    endfunction

    function automatic bit in_set(int c);
        foreach (togq[i]) if (togq[i] == c) return 1;
        return 0;
    endfunction

    function automatic void build_set();
        togq.delete();
        for (int g = 0; g < NG; g++) begin
            if (concat_en || g == int'(grp_sel)) begin
                for (int t = 0; t < NT; t++) begin
                    if (tog[g][t] != 13'h1FFF && !in_set(int'(tog[g][t])))
                        togq.push_back(int'(tog[g][t]));
                end
            end
        end
    endfunction

    function automatic logic model_level(int p);
        int g, s, l, r, q, w;
        logic lv;
        g  = eff_grp();
        lv = pl_a[g];
        s  = int'(st_a[g]);
        l  = int'(ln_a[g]);
        r  = int'(rp_a[g]);
        if (p < s || l == 0 || r == 0) return lv;
        q = p - s;
        if (q >= l * r) return lv;
        w = q % l;
        for (int c = 0; c <= w; c++) if (in_set(c)) lv = ~lv;
        return lv;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            active = 0;
            exp_out <= 1'b0;
        end else if (!enable) begin
            active = 0;
            exp_out <= pl_a[eff_grp()];
        end else if (line_start) begin
            active = 1;
            pos = -1;
            build_set();
            exp_out <= pl_a[eff_grp()];
        end else if (!active) begin
            exp_out <= pl_a[eff_grp()];
        end else if (pix_tick) begin
            pos = pos + 1;
            exp_out <= model_level(pos);
        end
    end

    always @(negedge clk) begin
        if (rst_n && checking && !finished) begin
            n_chk++;
            if (vclk !== exp_out) begin
                n_fail++;
                $display("FAIL %s: vclk_o=%b expected %b at %0t", cur_req, vclk, exp_out, $time);
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic clear_cfg();
        for (int g = 0; g < NG; g++) begin
            st_a[g] = '0; ln_a[g] = 13'd8; rp_a[g] = 5'd1; pl_a[g] = 1'b0;
            for (int t = 0; t < NT; t++) tog[g][t] = 13'h1FFF;
        end
    endtask

    task automatic scramble_bcd();
        for (int g = 1; g < NG; g++) begin
            st_a[g] = PW'($urandom % 40);
            ln_a[g] = PW'($urandom % 30);
            rp_a[g] = RW'($urandom % 8);
            pl_a[g] = 1'($urandom);
        end
    endtask

    task automatic run_line(int ncyc, int tick_mod, bit scramble);
        @(negedge clk);
        line_start = 1'b1;
        pix_tick   = 1'b0;
        @(negedge clk);
        line_start = 1'b0;
        for (int i = 0; i < ncyc; i++) begin
            pix_tick = (tick_mod <= 1) ? 1'b1 : (($urandom % tick_mod) == 0);
            if (scramble) scramble_bcd();
            @(negedge clk);
        end
        pix_tick = 1'b0;
    endtask

    initial begin
        clear_cfg();
        // R1: output low while reset held
        repeat (3) begin
            @(negedge clk);
            n_chk++;
            if (vclk !== 1'b0) begin
                n_fail++;
                $display("FAIL R1: vclk_o=%b expected 0", vclk);
            end
        end
        rst_n = 1'b1;
        checking = 1;

        // R2: disabled, strobes and ticks ignored, rests at polarity
        cur_req = "R2";
        pl_a[0] = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            line_start = 1'($urandom);
            pix_tick   = 1'($urandom);
        end
        line_start = 1'b0; pix_tick = 1'b0;
        enable = 1'b1;

        // R5: merged toggles from all four groups with unused slots
        cur_req = "R5";
        clear_cfg();
        st_a[0] = 13'd3; ln_a[0] = 13'd20; rp_a[0] = 5'd3; pl_a[0] = 1'b0;
        tog[0][0] = 13'd1;  tog[0][1] = 13'd5;
        tog[1][0] = 13'd7;  tog[1][2] = 13'd9;
        tog[2][1] = 13'd11; tog[2][3] = 13'd12;
        tog[3][0] = 13'd14; tog[3][3] = 13'd16;
        run_line(75, 1, 0);

        // R3: high polarity, late start, rests after final period
        cur_req = "R3";
        pl_a[0] = 1'b1; st_a[0] = 13'd9; rp_a[0] = 5'd2;
        run_line(70, 1, 0);

        // R7: short periods, several repeats, toggle on last slot
        cur_req = "R7";
        clear_cfg();
        st_a[0] = 13'd0; ln_a[0] = 13'd6; rp_a[0] = 5'd4;
        tog[0][0] = 13'd0; tog[1][0] = 13'd3; tog[2][0] = 13'd5;
        run_line(35, 1, 0);
        ln_a[0] = 13'd1; rp_a[0] = 5'd5;
        run_line(12, 1, 0);

        // R8: groups 1..3 identical, shared position with group 0
        cur_req = "R8";
        clear_cfg();
        st_a[0] = 13'd2; ln_a[0] = 13'd16; rp_a[0] = 5'd2;
        tog[0][0] = 13'd2; tog[0][1] = 13'd10; tog[0][2] = 13'd10;
        for (int g = 1; g < NG; g++) begin
            tog[g][0] = 13'd2; tog[g][1] = 13'd6;
        end
        run_line(45, 1, 0);

        // R4: merge off, one group alone with its own timing
        cur_req = "R4";
        concat_en = 1'b0;
        for (int s = 0; s < NG; s++) begin
            clear_cfg();
            grp_sel = 2'(s);
            for (int g = 0; g < NG; g++) begin
                st_a[g] = PW'(1 + g); ln_a[g] = PW'(7 + g); rp_a[g] = RW'(2 + (g % 2));
                pl_a[g] = 1'(g);
                tog[g][0] = PW'(g); tog[g][1] = PW'(g + 2); tog[g][3] = PW'(5);
            end
            run_line(40, 1, 0);
        end
        concat_en = 1'b1;
        grp_sel = 2'd0;

        // R6: other groups' timing fields scrambled every clock
        cur_req = "R6";
        for (int n = 0; n < 6; n++) begin
            clear_cfg();
            st_a[0] = PW'($urandom % 6); ln_a[0] = PW'(8 + $urandom % 10);
            rp_a[0] = RW'(1 + $urandom % 3); pl_a[0] = 1'($urandom);
            for (int g = 0; g < NG; g++)
                for (int t = 0; t < NT; t++)
                    tog[g][t] = (($urandom % 4) == 0) ? 13'h1FFF : PW'($urandom % 18);
            run_line(70, 1, 1);
        end

        // R9: sparse ticks
        cur_req = "R9";
        clear_cfg();
        st_a[0] = 13'd4; ln_a[0] = 13'd10; rp_a[0] = 5'd2;
        tog[0][0] = 13'd1; tog[1][0] = 13'd4; tog[2][0] = 13'd8;
        run_line(120, 3, 0);

        // R10: restart mid-pattern, strobe together with a tick
        cur_req = "R10";
        run_line(12, 1, 0);
        @(negedge clk);
        line_start = 1'b1; pix_tick = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int i = 0; i < 30; i++) @(negedge clk);
        pix_tick = 1'b0;
        // enable dropped mid-line, then a fresh line
        cur_req = "R2";
        run_line(8, 1, 0);
        enable = 1'b0;
        repeat (5) @(negedge clk);
        enable = 1'b1;
        cur_req = "R10";
        run_line(30, 1, 0);

        // R11: zero length or zero repeats
        cur_req = "R11";
        pl_a[0] = 1'b1;
        ln_a[0] = 13'd0;
        run_line(25, 1, 0);
        ln_a[0] = 13'd10; rp_a[0] = 5'd0;
        run_line(25, 1, 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule